// File: doc/BRIEF.md
# ECC Memory Write/Read Path Controller

This block sits between a bus master that moves 64-bit words and a storage array that keeps 64 data bits and 8 check bits per word. It encodes every stored word with an extended Hamming (72,64) code. It checks words on the way back and, if asked to, repairs single-bit faults. A write that leaves any byte lane idle cannot be encoded from the request alone. With protection on, such a write becomes a short read-modify-write: the old word is fetched and repaired, the new bytes are merged in, and the whole word is encoded again and written.

Requests use a valid/ready handshake that carries a word address, 64 bits of data and 8 lane enables. Read data returns on a one-cycle valid strobe in the cycle after acceptance. A four-bit control register sets four things independently: protection, repair, single-error reporting and multi-error reporting. A second, read-only register holds the word address of the most recent reported error. With protection off the block stores bytes as given, which suits scrub software that needs raw access.

Top module: `ecc_path_ctrl`

## Requirements
- R1: Register select 0 is the control register: bit 3 protection, bit 2 single-bit repair, bit 1 multi-bit report enable, bit 0 single-bit report enable. Bits 31:4 read as zero and writes to them have no effect. Register select 1 reads the last reported error address, zero-extended, and cannot be written.
- R2: After reset both registers read zero, `req_ready` is high and `rsp_valid`, `err_single` and `err_multi` are low.
- R3: With protection on, a write with all 8 lanes set completes in its accept cycle. A write with fewer lanes holds `req_ready` low for one cycle and then stores the merged word with fresh check bits.
- R4: With protection off, a write stores its enabled bytes in the accept cycle with no extra cycle. The check byte changes only on an all-lane write, and gets the code of the written data. Reads return the stored bits unchecked and never raise a report.
- R5: A word with odd overall parity is a single-bit error. When bit 2 is set a flipped data bit is repaired in the returned data; when bit 2 is clear the stored bits are returned.
- R6: A word with a non-zero syndrome and even overall parity is a multi-bit error. The stored bits are returned unchanged.
- R7: `err_single` and `err_multi` pulse for one cycle in the check cycle (the response cycle of a read, or the second cycle of a read-modify-write). They fire only when report bit 0 or bit 1 is set, respectively, and never both at once.
- R8: During a read-modify-write the fetched word is repaired whatever bit 2 says. A multi-bit error there cancels the write and leaves the stored word unchanged.
- R9: The protection mode is taken from bit 3 at the first accepted request after reset. Later writes to bit 3 change only its readback until the next reset.
- R10: A read is answered by `rsp_valid` high for exactly one cycle, the cycle after acceptance, with `req_ready` low in that cycle.
- R11: Each reported error stores its word address in the error address register. An error whose report is disabled leaves that register alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte lane enables, bit n covers data bits 8n+7:8n |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 64 | Read data |
| err_single | output | 1 | Single-bit error report pulse |
| err_multi | output | 1 | Multi-bit error report pulse |
| cfg_sel | input | 1 | Register select: 0 control, 1 error address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
On every cycle the assertions check four things. Protected writes always cover all nine lanes. A read-modify-write that meets a multi-bit error never writes. The two report pulses never coincide, and a report takes the failing address with it. They also check that the response strobe lasts a single cycle, that the locked mode does not move, and that raw mode never reports. Only the bench scenarios can show the data itself. They cover the repair of a flipped bit, the bytes kept by a merge, and raw writes that leave stale check bits for a later protected read to detect. They also show a change to bit 3 after the first access being ignored, which needs reset sequences and memory contents that survive them.

// File: rtl/ecc_path_pkg.sv
// Shared widths, types and code functions for the ECC path controller.
// Assumes a fixed 64-bit data word protected by 7 Hamming bits plus one
// overall parity bit; code positions 1..71 carry data at non-powers of two.
package ecc_path_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int POS_W  = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_RMW  = 2'd2
    } seq_state_e;

    // Control register, MSB first: protection, repair, multi report, single report.
    typedef struct packed {
        logic ecc_on;
        logic fix_on;
        logic multi_rep;
        logic single_rep;
    } ctrl_t;

    // XOR of the code positions of all set data bits.
    function automatic logic [POS_W-1:0] pos_syndrome(input logic [DATA_W-1:0] d);
        logic [POS_W-1:0] s;
        int k;
        s = '0;
        k = 0;
        for (int p = 1; p < WORD_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) s = s ^ POS_W'(p);
                k++;
            end
        end
        return s;
    endfunction

    // One-hot data mask for the data bit sitting at code position s (zero if none).
    function automatic logic [DATA_W-1:0] fix_mask(input logic [POS_W-1:0] s);
        logic [DATA_W-1:0] m;
        int k;
        m = '0;
        k = 0;
        for (int p = 1; p < WORD_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (POS_W'(p) == s) m[k] = 1'b1;
                k++;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// Check-byte generator: bits 6:0 are the Hamming bits, bit 7 makes the
// parity of all 72 stored bits even. Purely combinational.
module ecc_encoder
    import ecc_path_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic [POS_W-1:0] ham;

    // Hamming bits plus overall parity bit.
    always_comb begin
        ham   = pos_syndrome(data_i);
        chk_o = {^{data_i, ham}, ham};
    end
endmodule

// File: rtl/ecc_decoder.sv
// Check-and-repair stage: classifies a stored word as clean, single-bit
// (odd parity) or multi-bit (even parity, non-zero syndrome) and offers the
// repaired data. Assumes the check byte was produced by ecc_encoder.
module ecc_decoder
    import ecc_path_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              multi_o
);
    logic [POS_W-1:0] syn;
    logic             odd;

    // Syndrome, parity, classification and repair.
    always_comb begin
        syn      = pos_syndrome(data_i) ^ chk_i[POS_W-1:0];
        odd      = ^{data_i, chk_i};
        single_o = odd;
        multi_o  = !odd && (syn != '0);
        data_o   = odd ? (data_i ^ fix_mask(syn)) : data_i;
    end
endmodule

// File: rtl/ecc_store.sv
// Storage model: one byte-wide bank per lane, synchronous write with lane
// enables, registered read. Contents are not cleared by reset.
module ecc_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic [LANES-1:0]     lane_en_i,
    input  logic [LANES*8-1:0]   wdata_i,
    output logic [LANES*8-1:0]   rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] bank [DEPTH];
        logic [7:0] rd_q;

        // Lane write when both the port and this lane are enabled.
        always_ff @(posedge clk) begin
            if (wr_en_i && lane_en_i[l]) bank[addr_i] <= wdata_i[l*8 +: 8];
        end

        // Registered lane read.
        always_ff @(posedge clk) begin
            if (!rst_n)       rd_q <= '0;
            else if (rd_en_i) rd_q <= bank[addr_i];
        end

        assign rdata_o[l*8 +: 8] = rd_q;
    end
endmodule

// File: rtl/ecc_path_ctrl.sv
// ECC path controller top: request sequencing, read-modify-write merge,
// control and error-address registers, error report pulses.
// Assumes one outstanding request; a read answers one cycle after accept,
// and a partial protected write takes two cycles.
module ecc_path_ctrl
    import ecc_path_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [7:0]        req_be,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              err_single,
    output logic              err_multi,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    localparam int LANES       = DATA_W / 8;
    localparam int STORE_LANES = LANES + 1;

    seq_state_e              st_q, st_d;
    ctrl_t                   ctrl_q;
    logic                    locked_q, lock_val_q;
    logic [ADDR_W-1:0]       hold_addr_q, err_addr_q;
    logic [DATA_W-1:0]       hold_data_q;
    logic [LANES-1:0]        hold_be_q;

    logic                    accept, ecc_eff, full_lanes, need_rmw;
    logic                    direct_wr, rmw_wr, checking;
    logic                    mem_rd, mem_we;
    logic [ADDR_W-1:0]       mem_addr;
    logic [STORE_LANES-1:0]  mem_be;
    logic [DATA_W-1:0]       mem_wdata_d, merged, dec_data;
    logic [CHK_W-1:0]        enc_chk;
    logic [WORD_W-1:0]       mem_rword;
    logic                    dec_single, dec_multi;

    assign req_ready  = (st_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign ecc_eff    = locked_q ? lock_val_q : ctrl_q.ecc_on;
    assign full_lanes = &req_be;
    assign need_rmw   = accept && req_write && ecc_eff && !full_lanes;
    assign direct_wr  = accept && req_write && !need_rmw;
    assign rmw_wr     = (st_q == ST_RMW) && !dec_multi;

    // Merge: new bytes where the held request enabled a lane, repaired old bytes elsewhere.
    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*8 +: 8] = hold_be_q[l] ? hold_data_q[l*8 +: 8] : dec_data[l*8 +: 8];
    end

    assign mem_addr    = accept ? req_addr : hold_addr_q;
    assign mem_rd      = accept && (!req_write || need_rmw);
    assign mem_we      = direct_wr || rmw_wr;
    assign mem_wdata_d = (st_q == ST_RMW) ? merged : req_wdata;

    // Lane enables: whole word when protected, raw lanes (check lane only on full writes) otherwise.
    always_comb begin
        if (st_q == ST_RMW || ecc_eff) mem_be = '1;
        else                           mem_be = {full_lanes, req_be};
    end

    ecc_encoder u_enc (
        .data_i (mem_wdata_d),
        .chk_o  (enc_chk)
    );

    ecc_store #(.ADDR_W(ADDR_W), .LANES(STORE_LANES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (mem_addr),
        .rd_en_i   (mem_rd),
        .wr_en_i   (mem_we),
        .lane_en_i (mem_be),
        .wdata_i   ({enc_chk, mem_wdata_d}),
        .rdata_o   (mem_rword)
    );

    ecc_decoder u_dec (
        .data_i   (mem_rword[DATA_W-1:0]),
        .chk_i    (mem_rword[WORD_W-1:DATA_W]),
        .data_o   (dec_data),
        .single_o (dec_single),
        .multi_o  (dec_multi)
    );

    assign checking   = (st_q != ST_IDLE) && ecc_eff;
    assign rsp_valid  = (st_q == ST_READ);
    assign rsp_rdata  = (ecc_eff && dec_single && ctrl_q.fix_on) ? dec_data : mem_rword[DATA_W-1:0];
    assign err_single = checking && dec_single && ctrl_q.single_rep;
    assign err_multi  = checking && dec_multi && ctrl_q.multi_rep;
    assign cfg_rdata  = cfg_sel ? 32'(err_addr_q) : {28'd0, ctrl_q};

    // Sequencer next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept && !req_write) st_d = ST_READ;
                else if (need_rmw)        st_d = ST_RMW;
            end
            ST_READ: st_d = ST_IDLE;
            ST_RMW:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Sequencer state and held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            hold_addr_q <= '0;
            hold_data_q <= '0;
            hold_be_q   <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                hold_addr_q <= req_addr;
                hold_data_q <= req_wdata;
                hold_be_q   <= req_be;
            end
        end
    end

    // Protection mode lock taken at the first accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q   <= 1'b0;
            lock_val_q <= 1'b0;
        end else if (accept && !locked_q) begin
            locked_q   <= 1'b1;
            lock_val_q <= ctrl_q.ecc_on;
        end
    end

    // Control register: low four bits writable, the rest dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (cfg_we && !cfg_sel) ctrl_q <= ctrl_t'(cfg_wdata[3:0]);
    end

    // Error address capture on a reported error.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_addr_q <= '0;
        else if (err_single || err_multi) err_addr_q <= hold_addr_q;
    end

    // ---------------- assertions ----------------
    p_resv_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel && (cfg_wdata[31:4] != '0)) |=> (ctrl_q == ctrl_t'($past(cfg_wdata[3:0]))));

    p_full_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ecc_eff) |-> (&mem_be));

    p_raw_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_eff |-> (!err_single && !err_multi));

    p_class_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_single && dec_multi));

    p_one_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_multi));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RMW && dec_multi) |-> !mem_we);

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> (locked_q && $stable(lock_val_q)));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_addr_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single || err_multi) |=> (err_addr_q == $past(hold_addr_q)));
endmodule

// File: tb/ecc_path_ctrl_test.sv
// Bench: behavioural model of stored data versus the data the check bits
// were computed for; outputs compared at every falling edge.
module ecc_path_ctrl_test;
    localparam int PERIOD = 10;
    localparam int AW     = 6;
    localparam int WDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0] req_be = '0;
    logic cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic req_ready, rsp_valid, err_single, err_multi;
    logic [63:0] rsp_rdata;
    logic [31:0] cfg_rdata;

    always #(PERIOD/2) clk = ~clk;

    ecc_path_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .err_single(err_single), .err_multi(err_multi),
        .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // model state
    logic [63:0] m_data [1<<AW];
    logic [63:0] m_good [1<<AW];
    logic [3:0]  cfg_m;
    bit          ecc_m, lockd;
    int          last_err;
    bit          exp_ready, exp_rv, exp_se, exp_me;
    logic [63:0] exp_data;
    string       cur_req;
    int          n_total = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against model expectations
    always @(negedge clk) begin
        if (rst_n) begin
            check(req_ready === exp_ready, cur_req, "req_ready", 64'(req_ready), 64'(exp_ready));
            check(rsp_valid === exp_rv, cur_req, "rsp_valid", 64'(rsp_valid), 64'(exp_rv));
            check(err_single === exp_se, cur_req, "err_single", 64'(err_single), 64'(exp_se));
            check(err_multi === exp_me, cur_req, "err_multi", 64'(err_multi), 64'(exp_me));
            if (exp_rv) check(rsp_rdata === exp_data, cur_req, "rsp_rdata", rsp_rdata, exp_data);
        end
    end

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw, input logic [7:0] be);
        logic [63:0] r;
        r = old;
        for (int l = 0; l < 8; l++) if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    task automatic clear_exp;
        exp_ready = 1'b1; exp_rv = 1'b0; exp_se = 1'b0; exp_me = 1'b0; exp_data = '0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        clear_exp();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cfg_m = '0; lockd = 1'b0; ecc_m = 1'b0; last_err = 0;
        cur_req = "R2";
    endtask

    task automatic cfg_wr(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = v;
        @(posedge clk);
        cfg_m = v[3:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input bit sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #2;
        check(cfg_rdata === exp, req, sel ? "err_addr reg" : "ctrl reg", 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic txn(input bit wr, input int a, input logic [63:0] d, input logic [7:0] be, input string req);
        int flips;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(posedge clk);
        #1;
        cur_req = req;
        if (!lockd) begin lockd = 1'b1; ecc_m = cfg_m[3]; end
        flips = $countones(m_data[a] ^ m_good[a]);
        if (!wr) begin
            exp_rv = 1'b1; exp_ready = 1'b0; exp_data = m_data[a];
            if (ecc_m && flips == 1) begin
                exp_se = cfg_m[0];
                if (cfg_m[2]) exp_data = m_good[a];
                if (cfg_m[0]) last_err = a;
            end else if (ecc_m && flips >= 2) begin
                exp_me = cfg_m[1];
                if (cfg_m[1]) last_err = a;
            end
        end else if (ecc_m && be != 8'hFF) begin
            exp_ready = 1'b0;
            if (flips >= 2) begin
                exp_me = cfg_m[1];
                if (cfg_m[1]) last_err = a;
            end else begin
                exp_se = (flips == 1) && cfg_m[0];
                if (exp_se) last_err = a;
                m_data[a] = merge(m_good[a], d, be);
                m_good[a] = m_data[a];
            end
        end else if (ecc_m) begin
            m_data[a] = d; m_good[a] = d;
        end else begin
            m_data[a] = merge(m_data[a], d, be);
            if (be == 8'hFF) m_good[a] = d;
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        clear_exp();
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_1111_1111_1111);
    endfunction

    initial begin
        repeat (WDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=0", WDOG);
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin m_data[i] = '0; m_good[i] = '0; end
        do_reset();
        // R2: reset state of registers and outputs
        cfg_rd(1'b0, 32'h0, "R2");
        cfg_rd(1'b1, 32'h0, "R2");
        // R1: reserved bits dropped
        cfg_wr(32'hFFFF_FFF5);
        cfg_rd(1'b0, 32'h5, "R1");
        cfg_wr(32'h0000_000F);
        cfg_rd(1'b0, 32'hF, "R1");
        // R3, R10: full protected writes and clean reads
        for (int i = 0; i < 6; i++) txn(1'b1, i, pat(i), 8'hFF, "R3");
        for (int i = 0; i < 6; i++) txn(1'b0, i, '0, 8'h00, "R10");
        // R3: partial write merges
        txn(1'b1, 1, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F, "R3");
        txn(1'b0, 1, '0, 8'h00, "R3");
        // R9: clearing bit 3 after first access keeps read-modify-write
        cfg_wr(32'h7);
        cfg_rd(1'b0, 32'h7, "R9");
        txn(1'b1, 2, 64'hAA00_0000_0000_0000, 8'h80, "R9");
        txn(1'b0, 2, '0, 8'h00, "R9");
        cfg_wr(32'hF);

        // raw phase: inject faults, check bytes left stale (R4)
        do_reset();
        txn(1'b1, 3, m_data[3] ^ 64'h1, 8'h01, "R4");
        txn(1'b1, 4, m_data[4] ^ (64'h3 << 16), 8'h04, "R4");
        txn(1'b1, 5, m_data[5] ^ (64'h1 << 9), 8'h02, "R4");
        txn(1'b1, 0, m_data[0] ^ (64'h1 << 40), 8'h20, "R4");
        txn(1'b0, 3, '0, 8'h00, "R4");
        cfg_rd(1'b1, 32'h0, "R4");

        // protected phase: detection, repair and reporting
        do_reset();
        cfg_wr(32'hF);
        txn(1'b0, 3, '0, 8'h00, "R5");
        cfg_rd(1'b1, 32'd3, "R11");
        txn(1'b0, 4, '0, 8'h00, "R6");
        cfg_rd(1'b1, 32'd4, "R11");
        cfg_wr(32'hB);
        txn(1'b0, 0, '0, 8'h00, "R5");
        cfg_rd(1'b1, 32'd0, "R11");
        cfg_wr(32'hC);
        txn(1'b0, 3, '0, 8'h00, "R7");
        txn(1'b0, 4, '0, 8'h00, "R7");
        cfg_rd(1'b1, 32'd0, "R11");
        cfg_wr(32'h9);
        txn(1'b0, 4, '0, 8'h00, "R7");
        cfg_wr(32'hF);
        txn(1'b1, 5, 64'h0000_0000_0000_0077, 8'h01, "R8");
        cfg_rd(1'b1, 32'd5, "R11");
        txn(1'b0, 5, '0, 8'h00, "R8");
        txn(1'b1, 4, 64'h0000_0000_0000_0055, 8'h01, "R8");
        cfg_rd(1'b1, 32'd4, "R11");
        txn(1'b0, 4, '0, 8'h00, "R8");
        // R8: repair during merge even with repair disabled
        cfg_wr(32'hB);
        txn(1'b1, 0, 64'h0000_0000_0000_0011, 8'h01, "R8");
        txn(1'b0, 0, '0, 8'h00, "R8");

        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule